// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block is a clocked model of the control logic inside a byte-wide parallel NOR flash. It samples the host's active-low chip enable, write enable and output enable strobes together with the address and data buses. From these it extracts complete write cycles and decodes the key sequences that guard every change to the array. The array itself is a small register file that resets to the erased state.

A write cycle begins when both the chip enable and write enable strobes are low while output enable is high. The address is taken at that moment. The data is taken from the last sampled cycle before the cycle ends. A recognised sequence starts a program, sector erase or chip erase operation, or enters or leaves an identification view. Each operation runs for a number of clock cycles set by a parameter. While it runs, reads return a status byte and every write cycle is discarded. The array changes when the operation completes.

A host uses it like a flash part. It sends two unlock writes and a command byte, then the operand writes. It then polls the status byte until the toggle bit stops changing.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read-data enable is low, every array byte reads 0xFF and reads return array contents.
- R2: `data_oe_o` is high in the cycle after the sampled chip enable and output enable are both low, and low otherwise.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 followed by a write of D at address A start a program. After `PROG_CYC` cycles the byte at A (low `MEM_AW` address bits) holds its old value ANDed with D.
- R4: A write cycle takes its address when the cycle begins. It takes its data from the last sampled cycle before the cycle ends.
- R5: While an operation runs, a read returns a status byte. Bit 7 is the complement of bit 7 of the final programmed value for a program, and 0 for an erase. Bit 6 is 0 on the first read after the operation starts and inverts after each read. Bits 5..0 are 0.
- R6: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x30 at address A set every byte of the sector selected by address bits [MEM_AW-1:SECT_AW] of A to 0xFF after `SERASE_CYC` cycles. No other sector changes. With `SECT_AW`=12 the sector is 4 KiB.
- R7: The same five-write prefix followed by 0x10@0x5555 sets every array byte to 0xFF after `CERASE_CYC` cycles.
- R8: Every write cycle that ends while an operation runs is discarded. This covers command, operand and identification entry and exit writes.
- R9: A write that does not continue a valid sequence returns the sequencer to idle and to array read. It also leaves identification mode.
- R10: After 0xAA@0x5555, 0x55@0x2AAA, 0x90@0x5555, a read at address 0 returns 0xBF, at address 1 returns `DEV_ID`, and elsewhere returns 0x00. The same sequence with 0xF0 returns the block to array read.
- R11: A strobe pattern with output enable low is not a write cycle. It does not disturb a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data or status, zero when not driving |
| data_oe_o | output | 1 | Read-data enable (low means high impedance) |

## Verification
The bench changes the address and data buses partway through one write cycle. A design that captured both at the same edge would program the wrong byte or the wrong value. It sends a whole program sequence and an identification entry while a program runs. A design that still honoured commands while busy would alter a second byte or answer with the manufacturer code. Broken sequences are also covered: a bad second address, and a chip-erase byte sent to the wrong address. Both must leave the array untouched. A stray write while in identification mode must return reads to the array. An output-enable-low strobe placed in the middle of an unlock must not abort it. Status reads during a program and during an erase check the bit 7 polarity and the toggle phase, which starts at 0.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam logic [15:0] UNLK_A1    = 16'h5555;
  localparam logic [15:0] UNLK_A2    = 16'h2AAA;
  localparam logic [7:0]  KEY1       = 8'hAA;
  localparam logic [7:0]  KEY2       = 8'h55;
  localparam logic [7:0]  CMD_PROG   = 8'hA0;
  localparam logic [7:0]  CMD_ESETUP = 8'h80;
  localparam logic [7:0]  CMD_IDIN   = 8'h90;
  localparam logic [7:0]  CMD_SERASE = 8'h30;
  localparam logic [7:0]  CMD_CERASE = 8'h10;
  localparam logic [7:0]  MFR_CODE   = 8'hBF;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
  } seq_e;

  typedef enum logic [1:0] {OP_PROG, OP_SERASE, OP_CERASE} op_e;
endpackage

// File: rtl/flash_bus_sample.sv
module flash_bus_sample #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              rd_act_o,
  output logic              rd_end_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_end_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  logic ce_q, we_q, oe_q, wr_q, rd_q;
  logic [ADDR_W-1:0] addr_q, wr_addr_q;
  logic [7:0] data_q, wr_data_q;
  logic wr_act, rd_act;

  assign wr_act = !ce_q && !we_q && oe_q;
  assign rd_act = !ce_q && !oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q <= 1'b1; we_q <= 1'b1; oe_q <= 1'b1;
      wr_q <= 1'b0; rd_q <= 1'b0;
      addr_q <= '0; data_q <= '0;
      wr_addr_q <= '0; wr_data_q <= '0;
    end else begin
      ce_q <= ce_ni; we_q <= we_ni; oe_q <= oe_ni;
      addr_q <= addr_i; data_q <= data_i;
      wr_q <= wr_act; rd_q <= rd_act;
      if (wr_act && !wr_q) wr_addr_q <= addr_q;  // later falling strobe
      if (wr_act) wr_data_q <= data_q;           // last value before earlier rise
    end
  end

  assign rd_act_o  = rd_act;
  assign rd_end_o  = rd_q && !rd_act;
  assign addr_o    = addr_q;
  assign wr_end_o  = wr_q && !wr_act;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;

  // R11
  wr_qualify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_end_o |-> $past(!ce_ni && !we_ni && oe_ni, 2));
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MEM_AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              busy_i,
  output logic              id_mode_o,
  output logic              start_o,
  output op_e               op_o,
  output logic [MEM_AW-1:0] op_addr_o,
  output logic [7:0]        op_data_o
);
  seq_e st_q, st_d;
  logic id_q, id_d, start_q, go;
  op_e  op_q, kind_d;
  logic [MEM_AW-1:0] op_addr_q;
  logic [7:0] op_data_q;
  logic at1, k1, k2, blocked;

  assign at1     = addr_i == ADDR_W'(UNLK_A1);
  assign k1      = at1 && data_i == KEY1;
  assign k2      = addr_i == ADDR_W'(UNLK_A2) && data_i == KEY2;
  assign blocked = busy_i || start_q;

  always_comb begin
    st_d = st_q; id_d = id_q; go = 1'b0; kind_d = OP_PROG;
    if (cyc_i && !blocked) begin
      st_d = SQ_IDLE;
      unique case (st_q)
        SQ_IDLE: if (k1) st_d = SQ_U1; else id_d = 1'b0;
        SQ_U1:   if (k2) st_d = SQ_U2; else id_d = 1'b0;
        SQ_U2: begin
          if (at1 && data_i == CMD_PROG)        st_d = SQ_PGM;
          else if (at1 && data_i == CMD_ESETUP) st_d = SQ_E3;
          else if (at1 && data_i == CMD_IDIN)   id_d = 1'b1;
          else                                  id_d = 1'b0;  // exit or abort
        end
        SQ_PGM: begin go = 1'b1; kind_d = OP_PROG; end
        SQ_E3:  if (k1) st_d = SQ_E4; else id_d = 1'b0;
        SQ_E4:  if (k2) st_d = SQ_E5; else id_d = 1'b0;
        SQ_E5: begin
          if (data_i == CMD_SERASE) begin go = 1'b1; kind_d = OP_SERASE; end
          else if (at1 && data_i == CMD_CERASE) begin go = 1'b1; kind_d = OP_CERASE; end
          else id_d = 1'b0;
        end
        default: id_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE; id_q <= 1'b0; start_q <= 1'b0;
      op_q <= OP_PROG; op_addr_q <= '0; op_data_q <= '0;
    end else begin
      st_q <= st_d; id_q <= id_d; start_q <= go;
      if (go) begin
        op_q <= kind_d;
        op_addr_q <= addr_i[MEM_AW-1:0];
        op_data_q <= data_i;
      end
    end
  end

  assign id_mode_o = id_q;
  assign start_o   = start_q;
  assign op_o      = op_q;
  assign op_addr_o = op_addr_q;
  assign op_data_o = op_data_q;

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(st_q) && $stable(id_q));
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_seq_pkg::*;
#(
  parameter int PROG_CYC   = 200,
  parameter int SERASE_CYC = 2000,
  parameter int CERASE_CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAXC = (PROG_CYC > SERASE_CYC)
                      ? ((PROG_CYC > CERASE_CYC) ? PROG_CYC : CERASE_CYC)
                      : ((SERASE_CYC > CERASE_CYC) ? SERASE_CYC : CERASE_CYC);
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, len;

  always_comb begin
    unique case (op_i)
      OP_SERASE: len = CW'(SERASE_CYC);
      OP_CERASE: len = CW'(CERASE_CYC);
      default:   len = CW'(PROG_CYC);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= len;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = cnt_q != '0;
  assign done_o = cnt_q == CW'(1);

  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          MEM_AW     = 6,
  parameter int          SECT_AW    = 4,
  parameter int          PROG_CYC   = 200,
  parameter int          SERASE_CYC = 2000,
  parameter int          CERASE_CYC = 5000,
  parameter logic [7:0]  DEV_ID     = 8'hA7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o
);
  localparam int MEM_N = 1 << MEM_AW;

  logic rd_act, rd_end, wr_end, id_mode, start, busy, done, toggle_q;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0] wr_data, op_data, rd_val, prog_val;
  logic [MEM_AW-1:0] op_addr;
  op_e  op;
  logic [7:0] mem_q [MEM_N];

  flash_bus_sample #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .rd_act_o(rd_act), .rd_end_o(rd_end), .addr_o(rd_addr),
    .wr_end_o(wr_end), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  flash_cmd_decode #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dec (
    .clk_i, .rst_ni, .cyc_i(wr_end), .addr_i(wr_addr), .data_i(wr_data),
    .busy_i(busy), .id_mode_o(id_mode), .start_o(start), .op_o(op),
    .op_addr_o(op_addr), .op_data_o(op_data)
  );

  flash_op_timer #(.PROG_CYC(PROG_CYC), .SERASE_CYC(SERASE_CYC),
                   .CERASE_CYC(CERASE_CYC)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .op_i(op), .busy_o(busy), .done_o(done)
  );

  for (genvar g = 0; g < MEM_N; g++) begin : g_cell
    localparam logic [MEM_AW-1:0] IDX = MEM_AW'(g);
    logic hit_prog, hit_erase;
    assign hit_prog  = op == OP_PROG && op_addr == IDX;
    assign hit_erase = op == OP_CERASE ||
                       (op == OP_SERASE && op_addr[MEM_AW-1:SECT_AW] == IDX[MEM_AW-1:SECT_AW]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 mem_q[g] <= 8'hFF;
      else if (done && hit_erase)  mem_q[g] <= 8'hFF;
      else if (done && hit_prog)   mem_q[g] <= mem_q[g] & op_data;  // bits only clear
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              toggle_q <= 1'b0;
    else if (start)           toggle_q <= 1'b0;
    else if (busy && rd_end)  toggle_q <= ~toggle_q;
  end

  assign prog_val = mem_q[op_addr] & op_data;

  always_comb begin
    if (busy)
      rd_val = {(op == OP_PROG) ? ~prog_val[7] : 1'b0, toggle_q, 6'b0};
    else if (id_mode)
      rd_val = (rd_addr == '0) ? MFR_CODE :
               (rd_addr == ADDR_W'(1)) ? DEV_ID : 8'h00;
    else
      rd_val = mem_q[rd_addr[MEM_AW-1:0]];
  end

  assign data_oe_o = rd_act;
  assign data_o    = rd_act ? rd_val : 8'h00;

  // R2
  read_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !oe_ni) |=> data_oe_o);
  // R2
  read_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |=> !data_oe_o);
endmodule

// File: tb/flash_cmd_seq_test.sv
`timescale 1ns/1ps
module flash_cmd_seq_test;
  localparam int PROG = 60, SER = 90, CER = 130;
  localparam logic [7:0] DID = 8'hA7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b1, we = 1'b1, oe = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        doe;
  logic        pin_rd = 1'b0;
  int checks = 0, bad = 0;
  logic [7:0] ref_mem [64];
  logic [7:0] v;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(16), .MEM_AW(6), .SECT_AW(4), .PROG_CYC(PROG),
                  .SERASE_CYC(SER), .CERASE_CYC(CER), .DEV_ID(DID)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce), .we_ni(we), .oe_ni(oe),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe)
  );

  // R2 model: enable follows the sampled strobes one cycle later
  always @(posedge clk) pin_rd <= !ce && !oe;
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (doe !== pin_rd) begin
      bad++;
      $display("FAIL R2 data_oe got=%0b exp=%0b", doe, pin_rd);
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); ce = 1'b0; we = 1'b0; oe = 1'b1; addr = a; din = d;
    repeat (2) @(negedge clk);
    ce = 1'b1; we = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] r);
    @(negedge clk); ce = 1'b0; oe = 1'b0; we = 1'b1; addr = a;
    @(negedge clk); r = dout;
    ce = 1'b1; oe = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] r;
    rd(a, r);
    chk(tag, r, exp);
  endtask

  task automatic cmd3(input logic [7:0] c);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, c);
  endtask

  task automatic erase_pre();
    cmd3(8'h80); wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe idle", {7'b0, doe}, 8'h00);
    rd_chk("R1 cell 00", 16'h0000, ref_mem[0]);
    rd_chk("R1 cell 3f", 16'h003F, ref_mem[63]);

    // R3 program with status polling (R5)
    cmd3(8'hA0); wr(16'h0005, 8'h3C);
    rd(16'h0005, v); chk("R5 prog status 1", v, {~(ref_mem[5][7] & 1'b0), 1'b0, 6'b0});
    rd(16'h0005, v); chk("R5 prog status 2", v, {~(ref_mem[5][7] & 1'b0), 1'b1, 6'b0});
    repeat (PROG + 10) @(negedge clk);
    ref_mem[5] = ref_mem[5] & 8'h3C;
    rd_chk("R3 program", 16'h0005, ref_mem[5]);
    cmd3(8'hA0); wr(16'h0005, 8'hF0);
    repeat (PROG + 10) @(negedge clk);
    ref_mem[5] = ref_mem[5] & 8'hF0;
    rd_chk("R3 program and", 16'h0005, ref_mem[5]);

    // R8 commands during busy are dropped
    cmd3(8'hA0); wr(16'h0010, 8'h00);
    cmd3(8'hA0); wr(16'h0011, 8'h00);
    cmd3(8'h90);
    repeat (PROG + 10) @(negedge clk);
    ref_mem[16] = 8'h00;
    rd_chk("R8 first prog", 16'h0010, ref_mem[16]);
    rd_chk("R8 busy prog dropped", 16'h0011, ref_mem[17]);
    rd_chk("R8 busy id dropped", 16'h0000, ref_mem[0]);

    // R4 address at start, data at end
    cmd3(8'hA0);
    @(negedge clk); ce = 1'b0; we = 1'b0; oe = 1'b1; addr = 16'h0020; din = 8'hFF;
    @(negedge clk); addr = 16'h0021; din = 8'h0F;
    @(negedge clk); ce = 1'b1; we = 1'b1;
    repeat (2) @(negedge clk);
    repeat (PROG + 10) @(negedge clk);
    ref_mem[32] = 8'h0F;
    rd_chk("R4 addr at start", 16'h0020, ref_mem[32]);
    rd_chk("R4 other addr", 16'h0021, ref_mem[33]);

    // R11 oe-low strobe inside a sequence
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55);
    @(negedge clk); ce = 1'b0; we = 1'b0; oe = 1'b0; addr = 16'h1234; din = 8'h00;
    repeat (2) @(negedge clk);
    ce = 1'b1; we = 1'b1; oe = 1'b1;
    repeat (2) @(negedge clk);
    wr(16'h5555, 8'hA0); wr(16'h0022, 8'h5A);
    repeat (PROG + 10) @(negedge clk);
    ref_mem[34] = 8'h5A;
    rd_chk("R11 oe low ignored", 16'h0022, ref_mem[34]);

    // R9 bad second address aborts
    wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0023, 8'h00);
    repeat (PROG + 10) @(negedge clk);
    rd_chk("R9 abort no program", 16'h0023, ref_mem[35]);

    // R10 identification
    cmd3(8'h90);
    rd_chk("R10 mfr", 16'h0000, 8'hBF);
    rd_chk("R10 dev", 16'h0001, DID);
    rd_chk("R10 other", 16'h0002, 8'h00);
    cmd3(8'hF0);
    rd_chk("R10 exit", 16'h0005, ref_mem[5]);
    cmd3(8'h90);
    wr(16'h0003, 8'h12);
    rd_chk("R9 stray write leaves id", 16'h0000, ref_mem[0]);

    // R6 sector erase with erase status (R5)
    erase_pre(); wr(16'h0018, 8'h30);
    rd(16'h0018, v); chk("R5 erase status 1", v, 8'h00);
    rd(16'h0018, v); chk("R5 erase status 2", v, 8'h40);
    repeat (SER + 10) @(negedge clk);
    for (int i = 16; i < 32; i++) ref_mem[i] = 8'hFF;
    rd_chk("R6 sector erased", 16'h0010, ref_mem[16]);
    rd_chk("R6 sector0 kept", 16'h0005, ref_mem[5]);
    rd_chk("R6 sector2 kept", 16'h0020, ref_mem[32]);

    // R9 chip erase code at wrong address
    erase_pre(); wr(16'h0001, 8'h10);
    repeat (CER + 10) @(negedge clk);
    rd_chk("R9 bad chip erase", 16'h0005, ref_mem[5]);

    // R7 chip erase
    erase_pre(); wr(16'h5555, 8'h10);
    repeat (CER + 10) @(negedge clk);
    for (int i = 0; i < 64; i++) ref_mem[i] = 8'hFF;
    rd_chk("R7 chip erase a", 16'h0005, ref_mem[5]);
    rd_chk("R7 chip erase b", 16'h0022, ref_mem[34]);
    rd_chk("R7 chip erase c", 16'h003F, ref_mem[63]);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule